// File: doc/BRIEF.md
# PLL Setting and Chip Soft-Reset Register

This block is a single 64-bit control and status word on a simple register-access bus. It holds the multiplier and input-predivide settings for two PLLs, one for the processor core and one for the system bus, and drives them straight out to the PLLs. Any write changes the PLL setting outputs on the next clock edge. No staging copy exists, so software has to read, modify and write the word. Six software flag bits are kept in the same word. Only power-on reset clears them, so boot code can leave itself notes that outlast a soft reset.

A write with bit 0 set starts a whole-chip soft reset. That write gets no write acknowledge, which lets the bus go quiet before the reset takes hold. The sequencer drives `chip_reset_n` low for a fixed minimum hold time. It then waits until both PLL lock inputs are high and releases the reset, clearing bit 0 by itself. A lock wait that runs too long ends on a timeout: the reset is released anyway and a sticky `lock_timeout` output is set. The register itself ignores the soft reset it generates. Power-on reset (`por_n`) reloads it, taking the PLL settings from bootstrap pins. While the soft reset is active the bus port is not ready, and requests wait until the reset is released.

Top module: `pll_rst_ctrl_reg`

## Requirements
- R1: While `por_n` is low, the register loads the PLL settings from the bootstrap pins and clears the flags, bit 0 and `lock_timeout`. `chip_reset_n` is high after power-on reset.
- R2: The field layout is: bits 43:39 bus multiplier, bit 38 bus predivide, bits 37:33 core multiplier, bit 32 core predivide, bits 31:26 flags. A multiplier field holds the ratio minus one (00000 is x1, 11111 is x32). A predivide bit of 1 halves the PLL input. A write drives these fields onto the setting outputs from the next clock edge, and a read returns them.
- R3: Read bit 25 returns `bus_lock` and bit 24 returns `core_lock`, both sampled in the accept cycle. Writes to these bits have no effect. Bits 63:44 and 23:1 read as 0 whatever was written.
- R4: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A write with bit 0 clear pulses `rsp_wr_ack` for one cycle, in the cycle after acceptance. A read pulses `rsp_rd_valid` in the cycle after acceptance, with the data on `rsp_rdata`.
- R5: An accepted write with bit 0 set produces no `rsp_wr_ack`, and `chip_reset_n` is low from the next cycle.
- R6: `chip_reset_n` stays low for at least `HOLD_CYC` cycles. When both lock inputs are already high, it is low for exactly `HOLD_CYC`+1 cycles.
- R7: After the hold time, `chip_reset_n` stays low while either lock input is low. It goes high in the cycle after both are seen high. Bit 0 then reads 0.
- R8: If the locks are not both high by the last of `WAIT_CYC` wait cycles, the reset is released anyway. In that case `chip_reset_n` is low for exactly `HOLD_CYC`+`WAIT_CYC` cycles and `lock_timeout` goes high. `lock_timeout` stays high through later soft resets until power-on reset.
- R9: The PLL settings and the flags keep their values across a chip soft reset.
- R10: `req_ready` is low while `chip_reset_n` is low. A read issued then gets no response until after the release, and is served afterwards.
- R11: If both locks are seen high in the same cycle that the wait count expires, the lock wins. The reset is released at that point and `lock_timeout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| boot_bus_mult | input | 5 | Bootstrap bus multiplier code |
| boot_bus_prediv | input | 1 | Bootstrap bus predivide |
| boot_core_mult | input | 5 | Bootstrap core multiplier code |
| boot_core_prediv | input | 1 | Bootstrap core predivide |
| bus_lock | input | 1 | Bus PLL lock |
| core_lock | input | 1 | Core PLL lock |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Request may be accepted |
| rsp_wr_ack | output | 1 | Write acknowledge pulse |
| rsp_rd_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 64 | Read data |
| bus_mult | output | 5 | Bus PLL multiplier code |
| bus_prediv | output | 1 | Bus PLL predivide |
| core_mult | output | 5 | Core PLL multiplier code |
| core_prediv | output | 1 | Core PLL predivide |
| chip_reset_n | output | 1 | Chip soft reset, active low |
| lock_timeout | output | 1 | Sticky lock-wait timeout |

## Verification
The lock check and the timeout expiry can fall on the same clock edge. Whichever the sequencer tests first decides whether `lock_timeout` is set. The bench counts clock edges from the accepting edge of the reset write and raises both locks just before the edge on which the wait count reaches its limit. It then expects a release after exactly `HOLD_CYC`+`WAIT_CYC` low cycles with `lock_timeout` still low. A separate run with no locks at all shows the same low time ending with the flag set.

// File: rtl/pllrc_pkg.sv
// Shared field positions and types for the PLL setting / soft-reset register.
// Assumes a single 64-bit register; positions fixed by software decode.
package pllrc_pkg;
    localparam int REG_W     = 64;
    localparam int MUL_W     = 5;
    localparam int FLAG_W    = 6;
    localparam int CFG_LO    = 32;                 // lowest bit of the PLL settings
    localparam int CFG_W     = 2 * MUL_W + 2;      // two multipliers, two predivides
    localparam int CFG_HI    = CFG_LO + CFG_W - 1; // 43
    localparam int FLAG_LO   = 26;
    localparam int FLAG_HI   = FLAG_LO + FLAG_W - 1;
    localparam int BLOCK_BIT = 25;
    localparam int CLOCK_BIT = 24;
    localparam int RST_BIT   = 0;

    // Packed in bit order 43..32 so the struct maps straight onto the word.
    typedef struct packed {
        logic [MUL_W-1:0] bus_mult;
        logic             bus_prediv;
        logic [MUL_W-1:0] core_mult;
        logic             core_prediv;
    } pll_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pllrc_regfile.sv
// Register storage: PLL settings, software flags and the reset request bit.
// Only por_n clears or reloads it. Assumes wr_en and rst_done never
// coincide, since the bus port blocks writes while the sequencer is busy.
module pllrc_regfile
    import pllrc_pkg::*;
(
    input  logic                clk,
    input  logic                por_n,
    input  pll_cfg_t            boot_cfg,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                rst_done,
    input  logic                bus_lock,
    input  logic                core_lock,
    output pll_cfg_t            cfg,
    output logic [FLAG_W-1:0]   flags,
    output logic                rst_bit,
    output logic [REG_W-1:0]    image
);
    logic unused_wbits;
    assign unused_wbits = &{1'b0, wr_data[REG_W-1:CFG_HI+1], wr_data[BLOCK_BIT:RST_BIT+1]};

    // Settings and flags: bootstrap load on power-on, otherwise written directly.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg   <= boot_cfg;
            flags <= '0;
        end else if (wr_en) begin
            cfg   <= pll_cfg_t'(wr_data[CFG_HI:CFG_LO]);
            flags <= wr_data[FLAG_HI:FLAG_LO];
        end
    end

    // Reset request bit: set by software, cleared by the sequencer on release.
    always_ff @(posedge clk) begin
        if (!por_n)
            rst_bit <= 1'b0;
        else if (rst_done)
            rst_bit <= 1'b0;
        else if (wr_en)
            rst_bit <= wr_data[RST_BIT];
    end

    // Read image: reserved bits zero, lock bits live.
    always_comb begin
        image                  = '0;
        image[CFG_HI:CFG_LO]   = cfg;
        image[FLAG_HI:FLAG_LO] = flags;
        image[BLOCK_BIT]       = bus_lock;
        image[CLOCK_BIT]       = core_lock;
        image[RST_BIT]         = rst_bit;
    end
endmodule

// File: rtl/pllrc_rst_seq.sv
// Soft-reset sequencer: minimum hold, then wait for both PLL locks or a timeout.
// Assumes HOLD_CYC >= 1 and WAIT_CYC >= 1. Lock inputs are synchronous to clk.
module pllrc_rst_seq
    import pllrc_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    parameter int WAIT_CYC = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig,
    input  logic bus_lock,
    input  logic core_lock,
    output logic chip_reset_n,
    output logic idle,
    output logic done,
    output logic lock_timeout
);
    localparam int MAX_CYC = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             locked;
    logic             expire;

    assign locked = bus_lock & core_lock;
    assign expire = (cnt == WAIT_LAST);

    // State, cycle counter and sticky timeout; the lock check has priority over expiry.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state        <= SEQ_IDLE;
            cnt          <= '0;
            lock_timeout <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (trig) begin
                        state <= SEQ_HOLD;
                        cnt   <= '0;
                    end
                end
                SEQ_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        state <= SEQ_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (locked) begin
                        state <= SEQ_IDLE;
                    end else if (expire) begin
                        state        <= SEQ_IDLE;
                        lock_timeout <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        idle         = (state == SEQ_IDLE);
        chip_reset_n = idle;
        done         = (state == SEQ_WAIT) && (locked || expire);
    end
endmodule

// File: rtl/pllrc_bus_port.sv
// Bus port: accepts requests only while no soft reset runs, issues responses
// one cycle after acceptance and suppresses the ack of a reset-starting write.
module pllrc_bus_port
    import pllrc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_rst,
    input  logic              seq_idle,
    input  logic [REG_W-1:0]  image,
    output logic              req_ready,
    output logic              wr_en,
    output logic              rst_trig,
    output logic              rsp_wr_ack,
    output logic              rsp_rd_valid,
    output logic [REG_W-1:0]  rsp_rdata
);
    logic accept;

    // Handshake decode.
    always_comb begin
        req_ready = seq_idle;
        accept    = req_valid & req_ready;
        wr_en     = accept & req_write;
        rst_trig  = wr_en & req_rst;
    end

    // Response registers.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rsp_wr_ack   <= 1'b0;
            rsp_rd_valid <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_wr_ack   <= wr_en & ~req_rst;
            rsp_rd_valid <= accept & ~req_write;
            if (accept & ~req_write)
                rsp_rdata <= image;
        end
    end
endmodule

// File: rtl/pll_rst_ctrl_reg.sv
// Top: PLL setting register with a self-sequenced chip soft reset.
// por_n is the only reset for the register; chip_reset_n is generated here.
module pll_rst_ctrl_reg
    import pllrc_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    parameter int WAIT_CYC = 1024
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [MUL_W-1:0]  boot_bus_mult,
    input  logic              boot_bus_prediv,
    input  logic [MUL_W-1:0]  boot_core_mult,
    input  logic              boot_core_prediv,
    input  logic              bus_lock,
    input  logic              core_lock,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              rsp_wr_ack,
    output logic              rsp_rd_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic [MUL_W-1:0]  bus_mult,
    output logic              bus_prediv,
    output logic [MUL_W-1:0]  core_mult,
    output logic              core_prediv,
    output logic              chip_reset_n,
    output logic              lock_timeout
);
    pll_cfg_t          boot_cfg;
    pll_cfg_t          cfg;
    logic [FLAG_W-1:0] flags;
    logic              rst_bit;
    logic [REG_W-1:0]  image;
    logic              wr_en;
    logic              rst_trig;
    logic              seq_idle;
    logic              seq_done;

    // Bootstrap pins gathered into the settings layout.
    always_comb begin
        boot_cfg.bus_mult    = boot_bus_mult;
        boot_cfg.bus_prediv  = boot_bus_prediv;
        boot_cfg.core_mult   = boot_core_mult;
        boot_cfg.core_prediv = boot_core_prediv;
    end

    pllrc_bus_port i_port (
        .clk          (clk),
        .por_n        (por_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_rst      (req_wdata[RST_BIT]),
        .seq_idle     (seq_idle),
        .image        (image),
        .req_ready    (req_ready),
        .wr_en        (wr_en),
        .rst_trig     (rst_trig),
        .rsp_wr_ack   (rsp_wr_ack),
        .rsp_rd_valid (rsp_rd_valid),
        .rsp_rdata    (rsp_rdata)
    );

    pllrc_regfile i_regs (
        .clk       (clk),
        .por_n     (por_n),
        .boot_cfg  (boot_cfg),
        .wr_en     (wr_en),
        .wr_data   (req_wdata),
        .rst_done  (seq_done),
        .bus_lock  (bus_lock),
        .core_lock (core_lock),
        .cfg       (cfg),
        .flags     (flags),
        .rst_bit   (rst_bit),
        .image     (image)
    );

    pllrc_rst_seq #(
        .HOLD_CYC (HOLD_CYC),
        .WAIT_CYC (WAIT_CYC)
    ) i_seq (
        .clk          (clk),
        .por_n        (por_n),
        .trig         (rst_trig),
        .bus_lock     (bus_lock),
        .core_lock    (core_lock),
        .chip_reset_n (chip_reset_n),
        .idle         (seq_idle),
        .done         (seq_done),
        .lock_timeout (lock_timeout)
    );

    // Settings drive the PLLs directly.
    always_comb begin
        bus_mult    = cfg.bus_mult;
        bus_prediv  = cfg.bus_prediv;
        core_mult   = cfg.core_mult;
        core_prediv = cfg.core_prediv;
    end
endmodule

// File: rtl/pllrc_checker.sv
// Property checker for pll_rst_ctrl_reg, attached by bind.
module pllrc_checker #(
    parameter int HOLD_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       req_wdata0,
    input logic       rsp_wr_ack,
    input logic       rsp_rd_valid,
    input logic       chip_reset_n,
    input logic       lock_timeout,
    input logic       bus_lock,
    input logic       core_lock,
    input logic [4:0] bus_mult,
    input logic [4:0] core_mult,
    input logic       bus_prediv,
    input logic       core_prediv
);
    logic [15:0] low_cnt;
    logic        wr_acc;

    assign wr_acc = req_valid & req_ready & req_write;

    // Length of the current low phase of chip_reset_n, saturating.
    always_ff @(posedge clk) begin
        if (!por_n)
            low_cnt <= '0;
        else if (!chip_reset_n)
            low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
        else
            low_cnt <= '0;
    end

    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({rsp_wr_ack, rsp_rd_valid}));                                       // R4
    AST_RST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!por_n)
        (wr_acc && req_wdata0) |=> !rsp_wr_ack);                                     // R5
    AST_RST_WRITE_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
        (wr_acc && req_wdata0) |=> !chip_reset_n);                                   // R5
    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_reset_n) |-> (low_cnt >= 16'(HOLD_CYC)));                         // R6
    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_reset_n) |-> (($past(bus_lock) && $past(core_lock)) || lock_timeout)); // R7
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        lock_timeout |=> lock_timeout);                                              // R8
    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !wr_acc |=> ($stable(bus_mult) && $stable(core_mult) &&
                     $stable(bus_prediv) && $stable(core_prediv)));                  // R9
    AST_READY_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !chip_reset_n |-> !req_ready);                                               // R10
endmodule

bind pll_rst_ctrl_reg pllrc_checker #(.HOLD_CYC(HOLD_CYC)) i_chk (
    .clk          (clk),
    .por_n        (por_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_wdata0   (req_wdata[0]),
    .rsp_wr_ack   (rsp_wr_ack),
    .rsp_rd_valid (rsp_rd_valid),
    .chip_reset_n (chip_reset_n),
    .lock_timeout (lock_timeout),
    .bus_lock     (bus_lock),
    .core_lock    (core_lock),
    .bus_mult     (bus_mult),
    .core_mult    (core_mult),
    .bus_prediv   (bus_prediv),
    .core_prediv  (core_prediv)
);

// File: tb/test_pll_rst_ctrl_reg.sv
module test_pll_rst_ctrl_reg;
    localparam int HOLD = 16;
    localparam int WAIT = 40;
    localparam logic [63:0] FIELD_MASK = 64'h0000_0FFF_FC00_0000;
    localparam int NVEC = 6;
    // {bus_lock, core_lock, write data with bit 0 clear}
    localparam logic [65:0] VEC [NVEC] = '{
        {2'b11, 64'h0000_0000_0000_0000},
        {2'b01, 64'hFFFF_FFFF_FFFF_FFFE},
        {2'b10, 64'h0000_0A5A_A800_0000},
        {2'b00, 64'h0000_0555_5400_0000},
        {2'b11, 64'h1234_5678_9ABC_DEF0},
        {2'b10, 64'h0000_0800_0000_0002}
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [4:0]  boot_bus_mult = 5'd7;
    logic        boot_bus_prediv = 1'b1;
    logic [4:0]  boot_core_mult = 5'd12;
    logic        boot_core_prediv = 1'b0;
    logic        bus_lock = 1'b1, core_lock = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_wr_ack, rsp_rd_valid;
    logic [63:0] rsp_rdata;
    logic [4:0]  bus_mult, core_mult;
    logic        bus_prediv, core_prediv, chip_reset_n, lock_timeout;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pll_rst_ctrl_reg #(.HOLD_CYC(HOLD), .WAIT_CYC(WAIT)) i_pll_rst_ctrl_reg (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] img(input logic [63:0] w, input logic bl, input logic cl);
        return (w & FIELD_MASK) | (64'(bl) << 25) | (64'(cl) << 24);
    endfunction

    task automatic bus_write(input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(output logic [63:0] d, output logic v, output int waits, output logic early);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        waits = 0; early = 1'b0;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
            if (rsp_rd_valid) early = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_rd_valid; d = rsp_rdata;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!chip_reset_n && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, exp_img, w;
        logic v, early;
        int waits, n, k;

        do_por();
        // R1: bootstrap load and reset state
        @(negedge clk);
        chk("R1 bus_mult", 64'(bus_mult), 64'd7);
        chk("R1 core_mult", 64'(core_mult), 64'd12);
        chk("R1 prediv", 64'({bus_prediv, core_prediv}), 64'b10);
        chk("R1 chip_reset_n/timeout", 64'({chip_reset_n, lock_timeout}), 64'b10);
        bus_read(d, v, waits, early);
        exp_img = (64'd7 << 39) | (64'd1 << 38) | (64'd12 << 33) | (64'd1 << 25) | (64'd1 << 24);
        chk("R1 read image", d, exp_img);

        // R2 R3 R4: table walk of plain writes and reads
        for (int i = 0; i < NVEC; i++) begin
            w = VEC[i][63:0];
            bus_lock = VEC[i][65]; core_lock = VEC[i][64];
            bus_write(w);
            chk("R4 write ack", 64'(rsp_wr_ack), 64'd1);
            chk("R2 bus_mult", 64'(bus_mult), 64'(w[43:39]));
            chk("R2 bus_prediv", 64'(bus_prediv), 64'(w[38]));
            chk("R2 core_mult", 64'(core_mult), 64'(w[37:33]));
            chk("R2 core_prediv", 64'(core_prediv), 64'(w[32]));
            bus_read(d, v, waits, early);
            chk("R4 read valid", 64'(v), 64'd1);
            chk("R3 read image", d, img(w, VEC[i][65], VEC[i][64]));
        end
        @(negedge clk);
        chk("R4 single ack pulse", 64'(rsp_wr_ack), 64'd0);

        // R5 R6 R9: soft reset with locks already high
        bus_lock = 1'b1; core_lock = 1'b1;
        w = (64'd3 << 39) | (64'd20 << 33) | (64'd1 << 32) | (64'h2A << 26) | 64'd1;
        bus_write(w);
        chk("R5 no ack", 64'(rsp_wr_ack), 64'd0);
        chk("R5 reset asserted", 64'(chip_reset_n), 64'd0);
        count_low(n);
        chk("R6 low cycles", 64'(n), 64'(HOLD + 1));
        chk("R9 bus_mult kept", 64'(bus_mult), 64'd3);
        chk("R9 core_mult kept", 64'(core_mult), 64'd20);
        bus_read(d, v, waits, early);
        chk("R7 R9 image after release", d, img(w, 1'b1, 1'b1));

        // R10: read held off during soft reset
        bus_write(w);
        bus_read(d, v, waits, early);
        chk("R10 no early response", 64'(early), 64'd0);
        chk("R10 waited through reset", 64'(waits >= HOLD), 64'd1);
        chk("R10 served after release", 64'({v, chip_reset_n}), 64'b11);

        // R7: lock wait, one lock then both
        bus_lock = 1'b0; core_lock = 1'b0;
        bus_write(w);
        repeat (30) @(negedge clk);
        chk("R7 held without locks", 64'(chip_reset_n), 64'd0);
        bus_lock = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 held with one lock", 64'(chip_reset_n), 64'd0);
        core_lock = 1'b1;
        @(negedge clk);
        chk("R7 release after both locks", 64'({chip_reset_n, lock_timeout}), 64'b10);

        // R11: locks arrive on the expiring edge
        bus_lock = 1'b0; core_lock = 1'b0;
        bus_write(w);
        k = 1;
        while (!chip_reset_n && k < 5000) begin
            if (k == HOLD + WAIT) begin bus_lock = 1'b1; core_lock = 1'b1; end
            k++;
            @(negedge clk);
        end
        chk("R11 low cycles", 64'(k - 1), 64'(HOLD + WAIT));
        chk("R11 no timeout flag", 64'(lock_timeout), 64'd0);

        // R8: timeout release and stickiness
        bus_lock = 1'b0; core_lock = 1'b0;
        bus_write(w);
        count_low(n);
        chk("R8 low cycles", 64'(n), 64'(HOLD + WAIT));
        chk("R8 timeout set", 64'(lock_timeout), 64'd1);
        bus_lock = 1'b1; core_lock = 1'b1;
        bus_write(w);
        count_low(n);
        chk("R8 timeout sticky", 64'(lock_timeout), 64'd1);
        bus_read(d, v, waits, early);
        chk("R9 flags survive", 64'(d[31:26]), 64'h2A);

        // R1 R8: power-on reset clears flags and timeout, reloads bootstrap
        do_por();
        @(negedge clk);
        chk("R8 POR clears timeout", 64'(lock_timeout), 64'd0);
        bus_read(d, v, waits, early);
        chk("R1 POR reload", d, exp_img);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule